// File: doc/BRIEF.md
# Single-Error-Correcting Block Codec with Double-Error Flag

This block protects a 4-bit message with three Hamming check bits and one overall parity bit, giving an 8-bit codeword. A test stage between the encoder and the decoder can invert any chosen bits of that word, so the whole channel fits in one block. The decoder works out a 3-bit syndrome and the overall parity mismatch. It repairs any single flipped bit. It raises a carry flag when two bits are flipped, and in that case it leaves the message uncorrected.

Input words arrive on a valid/ready stream. Results leave on a second valid/ready stream after one register stage. Back-pressure rules:
- A word is accepted on a rising edge where `in_valid` and `in_ready` are both high.
- A result is taken on a rising edge where `out_valid` and `out_ready` are both high.
- `in_ready` is high whenever the output register is empty or is being drained in the same cycle.
- While the output is stalled, every output stays unchanged.

Top module: `hamc_codec`

## Requirements
- R1: Codeword layout: bits 3:0 hold message bits m1..m4 (bit 0 = m1). Bits 6:4 hold the check bits C1..C3. Bit 7 holds the overall parity bit. The check bits are C1=m1^m2^m3, C2=m1^m2^m4 and C3=m1^m3^m4. The parity bit makes the XOR of all 8 bits equal to 0.
- R2: Bit i of `in_errmask` inverts bit i of the received word, using the same layout as the codeword. The mask does not change `out_codeword`.
- R3: `out_syndrome` is {S1,S2,S3}, with S1 as bit 2. Each S bit is the XOR of the received message bits that feed its check bit and the received check bit itself. The syndrome patterns are m1=111, m2=110, m3=101, m4=011, C1=100, C2=010 and C3=001.
- R4: With no bit flipped, the syndrome is 000, `out_carry` is 0, `out_errpos` is 0 and `out_msg` equals the input message.
- R5: With exactly one bit flipped (including the parity bit), `out_carry` is 0. `out_errpos` is one-hot at the flipped bit position, and `out_msg` equals the original message.
- R6: With exactly two bits flipped, `out_carry` is 1 and `out_errpos` is 0. `out_msg` equals the received message bits, with no correction applied.
- R7: A result appears on the outputs, with `out_valid` high, in the cycle after its input was accepted. Back-to-back inputs give one result per cycle when `out_ready` is held high.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low and all outputs hold their values.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept an input word |
| in_msg | input | 4 | Message bits m1..m4 (bit 0 = m1) |
| in_errmask | input | 8 | Per-bit inversion mask applied to the received word |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts the result |
| out_codeword | output | 8 | Encoded word, before any inversion |
| out_syndrome | output | 3 | Syndrome {S1,S2,S3} |
| out_carry | output | 1 | Double error detected, not corrected |
| out_msg | output | 4 | Corrected message |
| out_errpos | output | 8 | One-hot position of the corrected bit, 0 if none |

## Verification
Two things can happen in the same cycle: a stalled result is drained and a new word is accepted. The bench provokes this by holding `out_ready` low while one result is pending and a second word waits on the input, then raising `out_ready`. It checks that the held result stayed intact through the stall and that the waiting word's result follows directly on the next cycle. The same overlap occurs on every cycle of the exhaustive sweep, where words stream back to back and each result must match the word sent one cycle earlier.

// File: rtl/hamc_pkg.sv
package hamc_pkg;
  localparam int MSG_W = 4;
  localparam int CHK_W = 3;
  localparam int SYN_W = CHK_W;
  localparam int CW_W  = MSG_W + CHK_W + 1;

  typedef logic [MSG_W-1:0] msg_t;
  typedef logic [CW_W-1:0]  cw_t;
  typedef logic [SYN_W-1:0] syn_t;

  typedef struct packed {
    cw_t  cw;
    syn_t syn;
    logic carry;
    msg_t msg;
    cw_t  pos;
  } res_t;

  // message bits feeding check bit k (bit 0 = m1)
  function automatic msg_t chk_taps(input int k);
    case (k)
      0:       chk_taps = 4'b0111;
      1:       chk_taps = 4'b1011;
      default: chk_taps = 4'b1101;
    endcase
  endfunction

  // syndrome produced by a flip at codeword position i
  function automatic syn_t col_pattern(input int i);
    syn_t p;
    p = '0;
    if (i < MSG_W) begin
      for (int k = 0; k < CHK_W; k++) begin
        msg_t t;
        t = chk_taps(k);
        p[SYN_W-1-k] = t[i];
      end
    end else if (i < MSG_W + CHK_W) begin
      p[SYN_W-1-(i-MSG_W)] = 1'b1;
    end
    col_pattern = p;
  endfunction
endpackage

// File: rtl/hamc_encoder.sv
module hamc_encoder
  import hamc_pkg::*;
(
  input  msg_t msg,
  output cw_t  cw
);
  logic [CHK_W-1:0] chk;

  for (genvar k = 0; k < CHK_W; k++) begin : g_chk
    assign chk[k] = ^(msg & chk_taps(k));
  end

  assign cw = {^{chk, msg}, chk, msg};
endmodule

// File: rtl/hamc_inject.sv
module hamc_inject
  import hamc_pkg::*;
(
  input  cw_t cw,
  input  cw_t mask,
  output cw_t rx
);
  for (genvar i = 0; i < CW_W; i++) begin : g_flip
    assign rx[i] = mask[i] ? ~cw[i] : cw[i];
  end
endmodule

// File: rtl/hamc_decoder.sv
module hamc_decoder
  import hamc_pkg::*;
(
  input  cw_t  rx,
  output syn_t syn,
  output logic carry,
  output msg_t msg,
  output cw_t  pos
);
  msg_t             rx_msg;
  logic [CHK_W-1:0] rx_chk;
  logic             g;

  assign rx_msg = rx[MSG_W-1:0];
  assign rx_chk = rx[MSG_W+CHK_W-1:MSG_W];
  assign g      = ^rx;

  for (genvar k = 0; k < CHK_W; k++) begin : g_syn
    assign syn[SYN_W-1-k] = (^(rx_msg & chk_taps(k))) ^ rx_chk[k];
  end

  for (genvar i = 0; i < CW_W - 1; i++) begin : g_hit
    assign pos[i] = g && (syn == col_pattern(i));
  end
  assign pos[CW_W-1] = g && (syn == '0);

  assign carry = (syn != '0) && !g;
  assign msg   = rx_msg ^ pos[MSG_W-1:0];
endmodule

// File: rtl/hamc_outreg.sv
module hamc_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
endmodule

// File: rtl/hamc_codec.sv
module hamc_codec
  import hamc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [3:0] in_msg,
  input  logic [7:0] in_errmask,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_codeword,
  output logic [2:0] out_syndrome,
  output logic       out_carry,
  output logic [3:0] out_msg,
  output logic [7:0] out_errpos
);
  localparam int RES_W = $bits(res_t);

  cw_t  enc_cw, rx_cw;
  res_t res_d, res_q;
  logic [RES_W-1:0] res_q_v;

  hamc_encoder u_enc (.msg(in_msg), .cw(enc_cw));
  hamc_inject  u_inj (.cw(enc_cw), .mask(in_errmask), .rx(rx_cw));
  hamc_decoder u_dec (
    .rx(rx_cw), .syn(res_d.syn), .carry(res_d.carry),
    .msg(res_d.msg), .pos(res_d.pos)
  );
  assign res_d.cw = enc_cw;

  hamc_outreg #(.W(RES_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(res_d),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(res_q_v)
  );
  assign res_q = res_t'(res_q_v);

  assign out_codeword = res_q.cw;
  assign out_syndrome = res_q.syn;
  assign out_carry    = res_q.carry;
  assign out_msg      = res_q.msg;
  assign out_errpos   = res_q.pos;

  p_pos_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(out_errpos));
  p_carry_nopos_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_carry |-> out_errpos == '0);
  p_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_syndrome == '0 |-> !out_carry);
  p_even_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (^out_codeword) == 1'b0);
  p_reset_r9: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

// File: tb/hamc_codec_bench.sv
module hamc_codec_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0, in_ready, out_valid, out_ready = 1, out_carry;
  logic [3:0] in_msg = 0, out_msg;
  logic [7:0] in_errmask = 0, out_codeword, out_errpos;
  logic [2:0] out_syndrome;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  hamc_codec u_hamc_codec (.*);

  // {msg, mask, syn, carry, out msg, pos}
  localparam int VW = 28;
  localparam logic [VW-1:0] VEC [8] = '{
    {4'b0000, 8'h00, 3'b000, 1'b0, 4'b0000, 8'h00},
    {4'b1011, 8'h01, 3'b111, 1'b0, 4'b1011, 8'h01},
    {4'b1011, 8'h80, 3'b000, 1'b0, 4'b1011, 8'h80},
    {4'b0101, 8'h10, 3'b100, 1'b0, 4'b0101, 8'h10},
    {4'b0110, 8'h03, 3'b001, 1'b1, 4'b0101, 8'h00},
    {4'b1111, 8'h48, 3'b010, 1'b1, 4'b0111, 8'h00},
    {4'b0001, 8'h88, 3'b011, 1'b1, 4'b1001, 8'h00},
    {4'b1100, 8'h20, 3'b010, 1'b0, 4'b1100, 8'h20}
  };

  function automatic logic [7:0] model_cw(input logic [3:0] m);
    logic c1, c2, c3, p;
    c1 = m[0] ^ m[1] ^ m[2];
    c2 = m[0] ^ m[1] ^ m[3];
    c3 = m[0] ^ m[2] ^ m[3];
    p  = m[0] ^ m[1] ^ m[2] ^ m[3] ^ c1 ^ c2 ^ c3;
    return {p, c3, c2, c1, m};
  endfunction

  function automatic logic [2:0] model_syn(input logic [7:0] r);
    return {r[0]^r[1]^r[2]^r[4], r[0]^r[1]^r[3]^r[5], r[0]^r[2]^r[3]^r[6]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, check result one cycle later
  task automatic run(input logic [3:0] m, input logic [7:0] k,
                     input logic [2:0] es, input logic ec,
                     input logic [3:0] em, input logic [7:0] ep);
    logic [7:0] ecw;
    ecw = model_cw(m);
    in_msg = m; in_errmask = k; in_valid = 1;
    @(negedge clk);
    chk(out_valid === 1'b1, "R7 out_valid", out_valid, 1);
    chk(out_codeword === ecw, "R1 codeword", out_codeword, ecw);
    chk(out_syndrome === es, "R3 syndrome", out_syndrome, es);
    chk(out_carry === ec, "R6 carry", out_carry, ec);
    chk(out_msg === em, "R5 message", out_msg, em);
    chk(out_errpos === ep, "R2 errpos", out_errpos, ep);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R9 out_valid after reset", out_valid, 0);
    chk(in_ready === 1'b1, "R9 in_ready after reset", in_ready, 1);

    // table of directed vectors (R3 syndrome patterns, R4/R5/R6)
    for (int v = 0; v < 8; v++) begin
      logic [VW-1:0] e;
      e = VEC[v];
      run(e[27:24], e[23:16], e[15:13], e[12], e[11:8], e[7:0]);
    end

    // exhaustive: all messages, all 0/1/2-bit masks, back to back (R4 R5 R6)
    for (int m = 0; m < 16; m++) begin
      for (int k = 0; k < 256; k++) begin
        logic [7:0] mk;
        logic [3:0] em;
        mk = 8'(k);
        if ($countones(mk) <= 2) begin
          em = ($countones(mk) == 2) ? (4'(m) ^ mk[3:0]) : 4'(m);
          run(4'(m), mk, model_syn(model_cw(4'(m)) ^ mk),
              $countones(mk) == 2, em,
              ($countones(mk) == 1) ? mk : 8'h00);
        end
      end
    end
    in_valid = 0;
    @(negedge clk);
    chk(out_valid === 1'b0, "R7 drain after last word", out_valid, 0);

    // back-pressure with simultaneous drain and accept (R8)
    out_ready = 0;
    in_msg = 4'b1010; in_errmask = 8'h00; in_valid = 1;
    @(negedge clk);
    in_msg = 4'b0011; in_errmask = 8'h04;
    @(negedge clk);
    @(negedge clk);
    chk(in_ready === 1'b0, "R8 in_ready low while stalled", in_ready, 0);
    chk(out_msg === 4'b1010 && out_codeword === model_cw(4'b1010),
        "R8 held result", out_msg, 4'b1010);
    chk(out_valid === 1'b1, "R8 out_valid held", out_valid, 1);
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk(out_valid === 1'b1 && out_errpos === 8'h04, "R8 next word follows", out_errpos, 8'h04);
    chk(out_msg === 4'b0011, "R5 corrected after stall", out_msg, 4'b0011);
    @(negedge clk);
    chk(out_valid === 1'b0, "R7 idle", out_valid, 0);

    // reset mid-stream (R9)
    in_valid = 1; out_ready = 0;
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk(out_valid === 1'b0, "R9 reset clears output", out_valid, 0);
    in_valid = 0; rst_n = 1;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule